// File: doc/BRIEF.md
# Three-Quarter Rate Fuse Block Encoder

This block turns a stream of raw key bytes into 32-bit words that can be loaded straight into the write registers of a one-time-programmable fuse block. The fuse block is protected by a three-quarter rate code. Every six data bytes carry two check bytes, so six bytes in give eight bytes out. The first check byte is the bitwise XOR of the group. The second is a position-weighted sum of the population counts of the six bytes. The eight bytes leave as two little-endian words.

Bytes arrive on a valid/ready interface. The first byte of a request is flagged as start-of-block and carries the declared length of the whole request. A declared length of zero, or one that is not a multiple of six, is refused. In that case an error pulse is raised and no word is emitted. Words leave on a valid/ready interface with a last flag. When the final word of a request is taken, a done pulse follows and every internal data and check register is wiped.

Top module: `fuse34_encoder`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, done and err are low after that edge, and in_ready is high once reset has been applied.
- R2: For each group of six accepted bytes b0..b5, the first word is {b3,b2,b1,b0} and bits 15:0 of the second word are {b5,b4}, with byte 0 in bits 7:0.
- R3: Bits 23:16 of the second word equal b0^b1^b2^b3^b4^b5.
- R4: Bits 31:24 of the second word equal the sum over i=0..5 of (i+1) times the number of ones in b_i, truncated to 8 bits.
- R5: Both check bytes restart at zero for each group, so the check bytes of a later group depend only on that group's bytes.
- R6: A start-of-block byte whose declared length is 0 or not a multiple of 6 raises err high for exactly the one cycle after that byte is accepted. No word is produced, and the following non-start bytes are accepted and dropped. A valid length never raises err.
- R7: A request of N bytes produces N/3 words, with out_last high on the final word only. A 24-byte request yields eight words.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_word stays unchanged on the next cycle.
- R9: done is high for exactly one cycle: the cycle after the word flagged out_last is accepted. It is low at every other time.
- R10: in_ready is low whenever out_valid is high, so no byte is taken while a group's words are pending.
- R11: In the cycle where done is high, out_word reads zero because the data and check registers have been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Encoder can take a byte |
| in_data | input | 8 | Input byte |
| in_sob | input | 1 | Marks the first byte of a request |
| in_len | input | LEN_W | Declared request length in bytes, sampled with the start byte |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | 32 | Encoded little-endian word |
| out_last | output | 1 | Final word of the request |
| done | output | 1 | One-cycle pulse after the final word is accepted |
| err | output | 1 | One-cycle pulse on a refused length |

## Verification
The hardest case to reach from the ports is a stall that lands on the second word of a group while later groups of the same request are still waiting. In that case the check registers must survive the stall and then restart cleanly. The stimulus reaches it by toggling out_ready at random during 24-byte requests. It also sends a two-group request whose first group is all ones and whose second group has a single bit per byte, so that any check value carried over from the previous group changes the second group's check bytes.

// File: rtl/fuse34_pkg.sv
// Package: shared constants, state type and helpers for the 3/4 fuse encoder.
// Assumes a fixed code shape of six data bytes plus two check bytes per group.
package fuse34_pkg;
    localparam int GROUP_BYTES = 6;
    localparam int WORD_W      = 32;
    localparam int BYTE_W      = 8;
    localparam int IDX_W       = $clog2(GROUP_BYTES);
    localparam int ONES_W      = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_EMIT_LO,
        ST_EMIT_HI
    } enc_state_e;

    // Count the set bits of one byte.
    function automatic logic [ONES_W-1:0] ones_in_byte(input logic [BYTE_W-1:0] b);
        logic [ONES_W-1:0] n;
        n = '0;
        for (int k = 0; k < BYTE_W; k++) begin
            n = n + ONES_W'(b[k]);
        end
        return n;
    endfunction
endpackage

// File: rtl/fuse34_len_check.sv
// Module: validates the declared request length and derives the group count.
// Assumes the length is presented together with the start-of-block byte.
module fuse34_len_check
    import fuse34_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic [LEN_W-1:0] len_i,
    output logic             len_ok_o,
    output logic [LEN_W-1:0] groups_o
);
    localparam logic [LEN_W-1:0] GB = LEN_W'(GROUP_BYTES);

    // Accept only non-zero whole multiples of the group size.
    always_comb begin
        groups_o = len_i / GB;
        len_ok_o = (len_i != '0) && ((len_i % GB) == '0);
    end
endmodule

// File: rtl/fuse34_check_accum.sv
// Module: holds the six data bytes of a group and accumulates both check bytes,
// one byte per cycle. Assumes bytes of a group are loaded at index 0..5 in order.
module fuse34_check_accum
    import fuse34_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clear_i,
    input  logic                                 load_i,
    input  logic [IDX_W-1:0]                     idx_i,
    input  logic [BYTE_W-1:0]                    byte_i,
    output logic [GROUP_BYTES-1:0][BYTE_W-1:0]   data_o,
    output logic [BYTE_W-1:0]                    xor_o,
    output logic [BYTE_W-1:0]                    wsum_o
);
    logic [BYTE_W-1:0] weight;
    logic [BYTE_W-1:0] term;

    // Weighted population-count term of the incoming byte.
    always_comb begin
        weight = BYTE_W'(idx_i) + BYTE_W'(1);
        term   = BYTE_W'(weight * BYTE_W'(ones_in_byte(byte_i)));
    end

    for (genvar g = 0; g < GROUP_BYTES; g++) begin : g_lane
        // Capture the byte for this lane, or wipe it.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                data_o[g] <= '0;
            end else if (load_i && (idx_i == IDX_W'(g))) begin
                data_o[g] <= byte_i;
            end
        end
    end

    // Accumulate the XOR and weighted-sum check bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            xor_o  <= '0;
            wsum_o <= '0;
        end else if (load_i) begin
            xor_o  <= xor_o ^ byte_i;
            wsum_o <= wsum_o + term;
        end
    end
endmodule

// File: rtl/fuse34_word_pack.sv
// Module: packs the eight code bytes of a group into one of two little-endian words.
// Assumes the low word carries bytes 0..3 and the high word bytes 4, 5 and the checks.
module fuse34_word_pack
    import fuse34_pkg::*;
(
    input  logic [GROUP_BYTES-1:0][BYTE_W-1:0] data_i,
    input  logic [BYTE_W-1:0]                  xor_i,
    input  logic [BYTE_W-1:0]                  wsum_i,
    input  logic                               sel_hi_i,
    output logic [WORD_W-1:0]                  word_o
);
    logic [WORD_W-1:0] lo_word;
    logic [WORD_W-1:0] hi_word;

    // Form both words and select the one being emitted.
    always_comb begin
        lo_word = {data_i[3], data_i[2], data_i[1], data_i[0]};
        hi_word = {wsum_i, xor_i, data_i[5], data_i[4]};
        word_o  = sel_hi_i ? hi_word : lo_word;
    end
endmodule

// File: rtl/fuse34_ctrl.sv
// Module: request sequencer. Takes bytes, tracks groups left, drives the word
// handshake and raises done/err pulses. Assumes len_ok/groups reflect in_len.
module fuse34_ctrl
    import fuse34_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic             in_sob_i,
    input  logic             len_ok_i,
    input  logic [LEN_W-1:0] groups_i,
    input  logic             out_ready_i,
    output logic             in_ready_o,
    output logic             acc_load_o,
    output logic [IDX_W-1:0] acc_idx_o,
    output logic             acc_clear_o,
    output logic             out_valid_o,
    output logic             out_last_o,
    output logic             sel_hi_o,
    output logic             done_o,
    output logic             err_o
);
    enc_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  groups_left_q;
    logic              start_ok;
    logic              start_bad;
    logic              hi_taken;

    // Decode handshakes and datapath controls from the current state.
    always_comb begin
        in_ready_o  = (state_q == ST_IDLE) || (state_q == ST_COLLECT);
        out_valid_o = (state_q == ST_EMIT_LO) || (state_q == ST_EMIT_HI);
        sel_hi_o    = (state_q == ST_EMIT_HI);
        out_last_o  = sel_hi_o && (groups_left_q == LEN_W'(1));
        start_ok    = (state_q == ST_IDLE) && in_valid_i && in_sob_i && len_ok_i;
        start_bad   = (state_q == ST_IDLE) && in_valid_i && in_sob_i && !len_ok_i;
        hi_taken    = sel_hi_o && out_ready_i;
        acc_load_o  = start_ok || ((state_q == ST_COLLECT) && in_valid_i);
        acc_idx_o   = (state_q == ST_IDLE) ? '0 : idx_q;
        acc_clear_o = hi_taken;
    end

    // Advance the request state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            idx_q         <= '0;
            groups_left_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        state_q       <= ST_COLLECT;
                        idx_q         <= IDX_W'(1);
                        groups_left_q <= groups_i;
                    end
                end
                ST_COLLECT: begin
                    if (in_valid_i) begin
                        if (idx_q == IDX_W'(GROUP_BYTES - 1)) begin
                            state_q <= ST_EMIT_LO;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                ST_EMIT_LO: begin
                    if (out_ready_i) begin
                        state_q <= ST_EMIT_HI;
                    end
                end
                ST_EMIT_HI: begin
                    if (out_ready_i) begin
                        groups_left_q <= groups_left_q - LEN_W'(1);
                        idx_q         <= '0;
                        state_q       <= out_last_o ? ST_IDLE : ST_COLLECT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Register the one-cycle done and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= hi_taken && out_last_o;
            err_o  <= start_bad;
        end
    end
endmodule

// File: rtl/fuse34_encoder.sv
// Module: top of the 3/4 rate fuse block encoder. Six bytes in become two
// little-endian words out (data, XOR check, weighted popcount check).
// Assumes in_len is valid with the start-of-block byte; other bytes ignore it.
module fuse34_encoder
    import fuse34_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_sob,
    input  logic [LEN_W-1:0] in_len,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_word,
    output logic             out_last,
    output logic             done,
    output logic             err
);
    logic                               len_ok;
    logic [LEN_W-1:0]                   groups;
    logic                               acc_load;
    logic [IDX_W-1:0]                   acc_idx;
    logic                               acc_clear;
    logic                               sel_hi;
    logic [GROUP_BYTES-1:0][BYTE_W-1:0] data;
    logic [BYTE_W-1:0]                  xor_byte;
    logic [BYTE_W-1:0]                  wsum_byte;

    fuse34_len_check #(.LEN_W(LEN_W)) u_len (
        .len_i    (in_len),
        .len_ok_o (len_ok),
        .groups_o (groups)
    );

    fuse34_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .in_sob_i    (in_sob),
        .len_ok_i    (len_ok),
        .groups_i    (groups),
        .out_ready_i (out_ready),
        .in_ready_o  (in_ready),
        .acc_load_o  (acc_load),
        .acc_idx_o   (acc_idx),
        .acc_clear_o (acc_clear),
        .out_valid_o (out_valid),
        .out_last_o  (out_last),
        .sel_hi_o    (sel_hi),
        .done_o      (done),
        .err_o       (err)
    );

    fuse34_check_accum u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (acc_clear),
        .load_i  (acc_load),
        .idx_i   (acc_idx),
        .byte_i  (in_data),
        .data_o  (data),
        .xor_o   (xor_byte),
        .wsum_o  (wsum_byte)
    );

    fuse34_word_pack u_pack (
        .data_i   (data),
        .xor_i    (xor_byte),
        .wsum_i   (wsum_byte),
        .sel_hi_i (sel_hi),
        .word_o   (out_word)
    );
endmodule

// File: rtl/fuse34_encoder_chk.sv
// Module: protocol checker for fuse34_encoder, bound to every instance.
// Assumes the synchronous active-low reset of the encoder.
module fuse34_encoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_word,
    input logic        out_last,
    input logic        done,
    input logic        err
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !done && !err));

    assert_no_input_while_emit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> done);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    assert_err_no_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !out_valid);

    assert_cleared_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_word == 32'h0));
endmodule

bind fuse34_encoder fuse34_encoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_last  (out_last),
    .done      (done),
    .err       (err)
);

// File: tb/fuse34_encoder_bench.sv
module fuse34_encoder_bench;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_data = '0;
    logic             in_sob = 1'b0;
    logic [LEN_W-1:0] in_len = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [31:0]      out_word;
    logic             out_last;
    logic             done;
    logic             err;

    int n_checks = 0;
    int n_fails  = 0;
    bit bp_mode  = 0;

    logic [31:0] exp_w[$];
    bit          exp_l[$];

    always #4 clk = ~clk;

    fuse34_encoder #(.LEN_W(LEN_W)) u_fuse34_encoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sob(in_sob), .in_len(in_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .out_last(out_last), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Expected encoding of one group, built from the requirement text (R2, R3, R4).
    task automatic push_group(input logic [7:0] b[6], input bit last);
        logic [7:0] x;
        logic [7:0] s;
        x = '0;
        s = '0;
        for (int i = 0; i < 6; i++) begin
            int pc;
            pc = 0;
            for (int k = 0; k < 8; k++) pc += b[i][k];
            x ^= b[i];
            s = 8'(s + 8'((i + 1) * pc));
        end
        exp_w.push_back({b[3], b[2], b[1], b[0]});
        exp_l.push_back(1'b0);
        exp_w.push_back({s, x, b[5], b[4]});
        exp_l.push_back(last);
    endtask

    // Driver: builds a request, queues expected words, feeds bytes.
    // pattern 0 random, 1 all ones, 2 all zeros, 3 first group ones then 0x01s.
    task automatic send_req(input int declared, input int nbytes, input int pattern);
        logic [7:0] bytes[$];
        bit good;
        bit err_pending;
        bit acc;
        good = (declared != 0) && (declared % 6 == 0);
        for (int k = 0; k < nbytes; k++) begin
            case (pattern)
                1: bytes.push_back(8'hFF);
                2: bytes.push_back(8'h00);
                3: bytes.push_back(k < 6 ? 8'hFF : 8'h01);
                default: bytes.push_back(8'($urandom));
            endcase
        end
        if (good) begin
            for (int g = 0; g < nbytes / 6; g++) begin
                logic [7:0] grp[6];
                for (int i = 0; i < 6; i++) grp[i] = bytes[g * 6 + i];
                push_group(grp, g == nbytes / 6 - 1);
            end
        end
        err_pending = 0;
        for (int k = 0; k < nbytes; k++) begin
            in_valid = 1'b1;
            in_data  = bytes[k];
            in_sob   = (k == 0);
            in_len   = LEN_W'(declared);
            do begin
                @(negedge clk);
                acc = in_ready;
                if (err_pending) begin
                    check(err == !good, "R6 err pulse", 32'(err), 32'(!good));
                    err_pending = 0;
                end
                @(posedge clk);
                #1;
            end while (!acc);
            if (k == 0) err_pending = 1;
        end
        in_valid = 1'b0;
        in_sob   = 1'b0;
        if (err_pending) begin
            @(negedge clk);
            check(err == !good, "R6 err pulse", 32'(err), 32'(!good));
        end
        if (!good) begin
            @(negedge clk);
            check(err == 1'b0, "R6 err one cycle", 32'(err), 32'h0);
        end
        wait (exp_w.size() == 0);
        repeat (4) @(posedge clk);
        #1;
    endtask

    // Backpressure generator.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = bp_mode ? 1'($urandom) : 1'b1;
        end
    end

    // Monitor / scoreboard, sampling at the falling edge.
    bit          last_hs_prev = 0;
    bit          stall_prev = 0;
    logic [31:0] word_prev = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (last_hs_prev || done) begin
                check(done == last_hs_prev, "R9 done timing", 32'(done), 32'(last_hs_prev));
                if (done) check(out_word == 32'h0, "R11 cleared after done", out_word, 32'h0);
            end
            if (out_valid && in_ready)
                check(1'b0, "R10 in_ready during emit", 32'(in_ready), 32'h0);
            if (stall_prev)
                check(out_valid && out_word == word_prev, "R8 hold under stall", out_word, word_prev);
            last_hs_prev = 0;
            if (out_valid && out_ready) begin
                if (exp_w.size() == 0) begin
                    check(1'b0, "R6 unexpected word", out_word, 32'h0);
                end else begin
                    logic [31:0] ew;
                    bit el;
                    ew = exp_w.pop_front();
                    el = exp_l.pop_front();
                    check(out_word == ew, "R2/R3/R4/R5 word", out_word, ew);
                    check(out_last == el, "R7 last flag", 32'(out_last), 32'(el));
                    last_hs_prev = out_last;
                end
            end
            stall_prev = out_valid && !out_ready;
            word_prev  = out_word;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !done && !err, "R1 reset outputs", {out_valid, done, err}, 32'h0);
        check(in_ready == 1'b1, "R1 reset in_ready", 32'(in_ready), 32'h1);
        check(out_word == 32'h0, "R1 reset word", out_word, 32'h0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        send_req(6, 6, 1);     // R4: all ones, weighted sum 168
        send_req(6, 6, 2);     // R3/R4 all zeros
        send_req(24, 24, 0);   // R7 full fuse block
        send_req(12, 12, 3);   // R5 check restart per group
        send_req(7, 7, 0);     // R6 not multiple of six
        send_req(0, 3, 0);     // R6 zero length
        bp_mode = 1;
        for (int r = 0; r < 6; r++) send_req(24, 24, 0); // R8 under stalls
        send_req(12, 12, 3);   // R5 with stalls
        send_req(13, 13, 0);   // R6 during stalls
        send_req(18, 18, 0);
        bp_mode = 0;
        repeat (10) @(posedge clk);
        check(exp_w.size() == 0, "R7 all words seen", 32'(exp_w.size()), 32'h0);
        summary();
    end
endmodule